// File: doc/BRIEF.md
# TLB Fault Context Loader

When address translation reports a fault, the fault handler needs several pieces of state before it starts: the address that faulted, that address's page number folded into the two page-table pointer registers, and a prefilled translation-entry key. This block builds that state. Each fault event is one of three kinds: refill (no matching entry), invalid (the entry's valid bit is clear), or modified (a store to a clean page). For each event the block loads four 64-bit registers and also chooses a 5-bit exception code and one of three handler vectors.

The surrounding pipeline pulses `ev_strobe` for one cycle. With that pulse it supplies the event kind, the access kind, the faulting virtual address, the current address-space identifier, the exception-level bit, the 64-bit addressing flag, and the present contents of the two pointer registers. The loaded values appear on the outputs after that clock edge. They stay there until the next accepted event. `load_done` marks the first cycle in which the new values are valid.

Top module: `tlb_fault_ctx_loader`

## Requirements
- R1: On an accepted event, `badva_q` takes all 64 bits of `fault_va`. This holds for every event kind.
- R2: On an accepted event, `ctx_q` bits 22:4 take `fault_va[31:13]`. Bits 63:23 and 3:0 take the same bits of `prev_ctx`.
- R3: On an accepted event, a 29-bit page value is formed with `fault_va[63:62]` in its top two bits and `fault_va[39:13]` below them. `xctx_q` bits 32:4 take this value, so bits 32:31 hold the region and bits 30:4 hold the page number. Bits 63:33 and 3:0 take the same bits of `prev_xctx`.
- R4: On an accepted event, `ehi_q` is loaded as follows:
  - bits 63:62 take `fault_va[63:62]`;
  - bits 39:13 take `fault_va[39:13]`;
  - bits 7:0 take `cur_asid`;
  - bits 61:40 and 12:8 are zero.
- R5: The event kind is encoded as refill=0, invalid=1, modified=2, and 3 is reserved. The access kind is encoded as fetch=0, load=1, store=2. Code 3 is treated as a load.
  - A modified event gives `exc_code`=1.
  - A refill or invalid event gives `exc_code`=3 when the access kind is store, and 2 otherwise.
- R6: For a refill event, `vec_sel` is set as follows, with vector encoding refill=0, extended refill=1, common=2:
  - common (2) when `exl` is 1;
  - otherwise extended refill (1) when `mode64` is 1;
  - otherwise refill (0).
- R7: Invalid and modified events always give `vec_sel`=2 (common), whatever the values of `exl` and `mode64`.
- R8: An event is accepted on a rising clock edge at which `ev_strobe` is 1 and `ev_kind` is not 3. The outputs change only at that edge. `load_done` is 1 for exactly the one following cycle.
- R9: No output changes when `ev_strobe` is 0, or when `ev_kind` is 3, and `load_done` stays 0.
- R10: While `rst_n` is low at a clock edge, every output register becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_strobe | input | 1 | One-cycle fault event pulse |
| ev_kind | input | 2 | Event kind: 0 refill, 1 invalid, 2 modified, 3 reserved |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| fault_va | input | 64 | Faulting virtual address |
| cur_asid | input | 8 | Current address-space identifier |
| exl | input | 1 | Exception level already set |
| mode64 | input | 1 | 64-bit addressing active |
| prev_ctx | input | 64 | Present context register value |
| prev_xctx | input | 64 | Present extended context register value |
| badva_q | output | 64 | Faulting-address register |
| ctx_q | output | 64 | Context register |
| xctx_q | output | 64 | Extended context register |
| ehi_q | output | 64 | Entry-key (entry high) register |
| exc_code | output | 5 | Exception code: 1 modify, 2 load miss, 3 store miss |
| vec_sel | output | 2 | Vector: 0 refill, 1 extended refill, 2 common |
| load_done | output | 1 | High for the cycle after an accepted event |

## Verification
Assertions check, at every accepted event, the following:
- the field placement in all four registers against the previous cycle's inputs;
- the modify code;
- the extended-refill and common vector choices;
- that the outputs stay stable and `load_done` stays low whenever no event is accepted.

Some behaviours only the bench scenarios show:
- the full code and vector matrix over access kind, `exl` and `mode64`;
- keeping all-ones and all-zeros backgrounds in the pointer registers;
- rejection of the reserved kind;
- a reset that lands on already loaded registers.

// File: rtl/tlbx_pkg.sv
// Package tlbx_pkg
// Shared encodings for the TLB fault context loader: event kinds, access
// kinds, handler vectors and exception codes. Assumes 2-bit kind fields.
package tlbx_pkg;

    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        EV_REFILL   = 2'd0,
        EV_INVALID  = 2'd1,
        EV_MODIFIED = 2'd2,
        EV_RSVD     = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        VEC_REFILL  = 2'd0,
        VEC_XREFILL = 2'd1,
        VEC_COMMON  = 2'd2
    } vec_sel_e;

    localparam logic [CODE_W-1:0] CODE_MOD  = 5'd1;
    localparam logic [CODE_W-1:0] CODE_TLBL = 5'd2;
    localparam logic [CODE_W-1:0] CODE_TLBS = 5'd3;

endpackage

// File: rtl/tlbx_field_merge.sv
// Module tlbx_field_merge
// Replaces a contiguous field of a register image with new bits and keeps
// every other bit. Purely combinational. Assumes LSB + FW <= W.
module tlbx_field_merge #(
    parameter int W   = 64,
    parameter int LSB = 4,
    parameter int FW  = 19
) (
    input  logic [W-1:0]  old_val,
    input  logic [FW-1:0] field,
    output logic [W-1:0]  new_val
);

    // Per-bit choice between the inserted field and the kept old bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i >= LSB && i < LSB + FW) begin : g_ins
            assign new_val[i] = field[i-LSB];
        end else begin : g_keep
            assign new_val[i] = old_val[i];
        end
    end

endmodule

// File: rtl/tlbx_hi_form.sv
// Module tlbx_hi_form
// Builds the translation-entry key image: region bits on top, a zero gap,
// the page number, a zero gap, then the address-space identifier.
// Assumes VPN_LO >= ASID_W and VPN_HI < VA_W - REG_W.
module tlbx_hi_form #(
    parameter int VA_W   = 64,
    parameter int REG_W  = 2,
    parameter int VPN_HI = 39,
    parameter int VPN_LO = 13,
    parameter int ASID_W = 8,
    localparam int VPN_W   = VPN_HI - VPN_LO + 1,
    localparam int ZERO_HI = VA_W - REG_W - VPN_HI - 1,
    localparam int ZERO_LO = VPN_LO - ASID_W
) (
    input  logic [REG_W-1:0]  region,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output logic [VA_W-1:0]   ehi_img
);

    // Concatenate the fields with zero fill in the unused address bits.
    assign ehi_img = {region, {ZERO_HI{1'b0}}, vpn, {ZERO_LO{1'b0}}, asid};

endmodule

// File: rtl/tlbx_cause_sel.sv
// Module tlbx_cause_sel
// Chooses the exception code and handler vector from the event kind,
// access kind, exception level and addressing mode. Combinational.
// Assumes the reserved event kind is filtered out by the caller.
module tlbx_cause_sel
    import tlbx_pkg::*;
(
    input  logic [1:0]        ev_kind,
    input  logic [1:0]        acc_kind,
    input  logic              exl,
    input  logic              mode64,
    output logic [CODE_W-1:0] code,
    output logic [1:0]        vec
);

    // Code: modify for a clean-page store, otherwise load or store miss.
    always_comb begin
        if (ev_kind == EV_MODIFIED) begin
            code = CODE_MOD;
        end else if (acc_kind == ACC_STORE) begin
            code = CODE_TLBS;
        end else begin
            code = CODE_TLBL;
        end
    end

    // Vector: only a refill at base level leaves the common entry point.
    always_comb begin
        if (ev_kind != EV_REFILL || exl) begin
            vec = VEC_COMMON;
        end else if (mode64) begin
            vec = VEC_XREFILL;
        end else begin
            vec = VEC_REFILL;
        end
    end

endmodule

// File: rtl/tlb_fault_ctx_loader.sv
// Module tlb_fault_ctx_loader
// Top of the fault context loader. On an accepted fault event it captures
// the faulting address, merges the page number into both pointer register
// layouts, forms the entry key, and registers the code and vector.
// Assumes ev_strobe is a single-cycle pulse qualified by the pipeline.
module tlb_fault_ctx_loader
    import tlbx_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int ASID_W    = 8,
    parameter int REG_W     = 2,
    parameter int VPN_HI    = 39,
    parameter int VPN_LO    = 13,
    parameter int CTX_VA_HI = 31,
    parameter int CTX_LSB   = 4,
    parameter int XCTX_LSB  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_strobe,
    input  logic [1:0]        ev_kind,
    input  logic [1:0]        acc_kind,
    input  logic [VA_W-1:0]   fault_va,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              exl,
    input  logic              mode64,
    input  logic [VA_W-1:0]   prev_ctx,
    input  logic [VA_W-1:0]   prev_xctx,
    output logic [VA_W-1:0]   badva_q,
    output logic [VA_W-1:0]   ctx_q,
    output logic [VA_W-1:0]   xctx_q,
    output logic [VA_W-1:0]   ehi_q,
    output logic [CODE_W-1:0] exc_code,
    output logic [1:0]        vec_sel,
    output logic              load_done
);

    localparam int VPN_W  = VPN_HI - VPN_LO + 1;
    localparam int CF_W   = CTX_VA_HI - VPN_LO + 1;
    localparam int XF_W   = REG_W + VPN_W;
    localparam int CTX_TOP  = CTX_LSB + CF_W - 1;
    localparam int XCTX_TOP = XCTX_LSB + XF_W - 1;

    logic                accept;
    logic [REG_W-1:0]    region;
    logic [VPN_W-1:0]    vpn;
    logic [XF_W-1:0]     xfield;
    logic [VA_W-1:0]     ctx_n;
    logic [VA_W-1:0]     xctx_n;
    logic [VA_W-1:0]     ehi_n;
    logic [CODE_W-1:0]   code_n;
    logic [1:0]          vec_n;

    // Event qualification: the reserved kind is dropped.
    assign accept = ev_strobe && (ev_kind != EV_RSVD);

    // Slices of the faulting address shared by the merges.
    assign region = fault_va[VA_W-1 -: REG_W];
    assign vpn    = fault_va[VPN_HI:VPN_LO];
    assign xfield = {region, vpn};

    tlbx_field_merge #(.W(VA_W), .LSB(CTX_LSB), .FW(CF_W)) u_ctx (
        .old_val (prev_ctx),
        .field   (fault_va[CTX_VA_HI:VPN_LO]),
        .new_val (ctx_n)
    );

    tlbx_field_merge #(.W(VA_W), .LSB(XCTX_LSB), .FW(XF_W)) u_xctx (
        .old_val (prev_xctx),
        .field   (xfield),
        .new_val (xctx_n)
    );

    tlbx_hi_form #(
        .VA_W(VA_W), .REG_W(REG_W), .VPN_HI(VPN_HI),
        .VPN_LO(VPN_LO), .ASID_W(ASID_W)
    ) u_hi (
        .region  (region),
        .vpn     (vpn),
        .asid    (cur_asid),
        .ehi_img (ehi_n)
    );

    tlbx_cause_sel u_cause (
        .ev_kind  (ev_kind),
        .acc_kind (acc_kind),
        .exl      (exl),
        .mode64   (mode64),
        .code     (code_n),
        .vec      (vec_n)
    );

    // Register bank: loaded only in the cycle of an accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            badva_q  <= '0;
            ctx_q    <= '0;
            xctx_q   <= '0;
            ehi_q    <= '0;
            exc_code <= '0;
            vec_sel  <= '0;
        end else if (accept) begin
            badva_q  <= fault_va;
            ctx_q    <= ctx_n;
            xctx_q   <= xctx_n;
            ehi_q    <= ehi_n;
            exc_code <= code_n;
            vec_sel  <= vec_n;
        end
    end

    // Completion flag: follows the accepted event by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_done <= 1'b0;
        end else begin
            load_done <= accept;
        end
    end

    assert_badva_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> badva_q == $past(fault_va));

    assert_ctx_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ctx_q[CTX_TOP:CTX_LSB] == $past(fault_va[CTX_VA_HI:VPN_LO]))
                && (ctx_q[CTX_LSB-1:0] == $past(prev_ctx[CTX_LSB-1:0]))
                && (ctx_q[VA_W-1:CTX_TOP+1] == $past(prev_ctx[VA_W-1:CTX_TOP+1])));

    assert_xctx_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (xctx_q[XCTX_TOP -: REG_W] == $past(fault_va[VA_W-1 -: REG_W]))
                && (xctx_q[XCTX_LSB+VPN_W-1:XCTX_LSB] == $past(fault_va[VPN_HI:VPN_LO]))
                && (xctx_q[VA_W-1:XCTX_TOP+1] == $past(prev_xctx[VA_W-1:XCTX_TOP+1])));

    assert_ehi_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ehi_q[ASID_W-1:0] == $past(cur_asid))
                && (ehi_q[VPN_LO-1:ASID_W] == '0)
                && (ehi_q[VA_W-REG_W-1:VPN_HI+1] == '0));

    assert_mod_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ev_kind == EV_MODIFIED) |=> exc_code == CODE_MOD);

    assert_xrefill_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ev_kind == EV_REFILL && !exl && mode64) |=> vec_sel == VEC_XREFILL);

    assert_common_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ev_kind != EV_REFILL) |=> vec_sel == VEC_COMMON);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> load_done);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(badva_q) && $stable(ctx_q) && $stable(xctx_q)
                 && $stable(ehi_q) && $stable(exc_code) && $stable(vec_sel) && !load_done);

endmodule

// File: tb/sim_tlb_fault_ctx_loader.sv
`timescale 1ns/1ps
module sim_tlb_fault_ctx_loader;

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  acc;
        logic        exl;
        logic        m64;
        logic [63:0] va;
        logic [7:0]  asid;
        logic [63:0] pctx;
        logic [63:0] pxctx;
        logic [4:0]  code;
        logic [1:0]  vec;
    } stim_t;

    localparam int NV = 10;
    localparam stim_t TBL [NV] = '{
        '{2'd0, 2'd1, 1'b0, 1'b0, 64'h0000_0000_8765_4000, 8'h11, 64'h0, 64'h0, 5'd2, 2'd0},
        '{2'd0, 2'd2, 1'b0, 1'b1, 64'hC000_00AB_CDEF_2000, 8'hA5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd3, 2'd1},
        '{2'd0, 2'd0, 1'b1, 1'b1, 64'h4000_0012_3456_7FFF, 8'h3C, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 5'd2, 2'd2},
        '{2'd0, 2'd2, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 64'h0, 64'h0, 5'd3, 2'd2},
        '{2'd1, 2'd1, 1'b0, 1'b1, 64'h8000_0055_AAAA_E000, 8'h01, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 5'd2, 2'd2},
        '{2'd1, 2'd2, 1'b0, 1'b0, 64'h0000_0000_0000_2000, 8'h80, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'd3, 2'd2},
        '{2'd1, 2'd0, 1'b1, 1'b1, 64'h3FFF_FF00_0000_1FFF, 8'h7E, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd2, 2'd2},
        '{2'd2, 2'd2, 1'b0, 1'b1, 64'h5A5A_5A5A_5A5A_5A5A, 8'h42, 64'hDEAD_BEEF_CAFE_F00D, 64'h0123_4567_89AB_CDEF, 5'd1, 2'd2},
        '{2'd2, 2'd1, 1'b0, 1'b0, 64'hA5A5_A5A5_A5A5_A5A5, 8'h24, 64'h0, 64'h0, 5'd1, 2'd2},
        '{2'd0, 2'd3, 1'b0, 1'b1, 64'h8000_00FF_FFFF_E000, 8'h99, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 5'd2, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ev_strobe;
    logic [1:0]  ev_kind;
    logic [1:0]  acc_kind;
    logic [63:0] fault_va;
    logic [7:0]  cur_asid;
    logic        exl;
    logic        mode64;
    logic [63:0] prev_ctx;
    logic [63:0] prev_xctx;
    logic [63:0] badva_q;
    logic [63:0] ctx_q;
    logic [63:0] xctx_q;
    logic [63:0] ehi_q;
    logic [4:0]  exc_code;
    logic [1:0]  vec_sel;
    logic        load_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tlb_fault_ctx_loader u0 (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .ev_kind(ev_kind),
        .acc_kind(acc_kind), .fault_va(fault_va), .cur_asid(cur_asid),
        .exl(exl), .mode64(mode64), .prev_ctx(prev_ctx), .prev_xctx(prev_xctx),
        .badva_q(badva_q), .ctx_q(ctx_q), .xctx_q(xctx_q), .ehi_q(ehi_q),
        .exc_code(exc_code), .vec_sel(vec_sel), .load_done(load_done)
    );

    function automatic logic [63:0] exp_ctx(logic [63:0] va, logic [63:0] p);
        logic [63:0] m = 64'h0000_0000_007F_FFF0;
        return (p & ~m) | (64'(va[31:13]) << 4);
    endfunction

    function automatic logic [63:0] exp_xctx(logic [63:0] va, logic [63:0] p);
        logic [63:0] m = 64'h0000_0001_FFFF_FFF0;
        logic [28:0] f = {va[63:62], va[39:13]};
        return (p & ~m) | (64'(f) << 4);
    endfunction

    function automatic logic [63:0] exp_ehi(logic [63:0] va, logic [7:0] a);
        return {va[63:62], 22'b0, va[39:13], 5'b0, a};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    logic [63:0] e_badva, e_ctx, e_xctx, e_ehi;
    logic [4:0]  e_code;
    logic [1:0]  e_vec;

    task automatic check_all(string tag);
        check({tag, " R1 badva"}, badva_q, e_badva);
        check({tag, " R2 ctx"},   ctx_q,   e_ctx);
        check({tag, " R3 xctx"},  xctx_q,  e_xctx);
        check({tag, " R4 ehi"},   ehi_q,   e_ehi);
        check({tag, " R5 code"},  64'(exc_code), 64'(e_code));
        check({tag, " R6/R7 vec"}, 64'(vec_sel), 64'(e_vec));
    endtask

    task automatic drive(stim_t s, logic strobe);
        ev_kind   = s.kind;
        acc_kind  = s.acc;
        exl       = s.exl;
        mode64    = s.m64;
        fault_va  = s.va;
        cur_asid  = s.asid;
        prev_ctx  = s.pctx;
        prev_xctx = s.pxctx;
        ev_strobe = strobe;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R8 act=hung exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(TBL[0], 1'b0);
        repeat (3) @(negedge clk);
        e_badva = '0; e_ctx = '0; e_xctx = '0; e_ehi = '0; e_code = '0; e_vec = '0;
        check_all("reset R10");
        check("reset R10 done", 64'(load_done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: every event kind, access kind and mode combination.
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i], 1'b1);
            #1;
            check("pre-edge R8 badva", badva_q, e_badva);
            @(negedge clk);
            ev_strobe = 1'b0;
            e_badva = TBL[i].va;
            e_ctx   = exp_ctx(TBL[i].va, TBL[i].pctx);
            e_xctx  = exp_xctx(TBL[i].va, TBL[i].pxctx);
            e_ehi   = exp_ehi(TBL[i].va, TBL[i].asid);
            e_code  = TBL[i].code;
            e_vec   = TBL[i].vec;
            check_all($sformatf("vec%0d", i));
            check("R8 done high", 64'(load_done), 64'd1);
            @(negedge clk);
            check("R8 done one cycle", 64'(load_done), 64'd0);
        end

        // Reserved kind with strobe: nothing loads.
        begin
            stim_t s = TBL[1];
            s.kind = 2'd3;
            s.va = 64'h1111_2222_3333_4444;
            drive(s, 1'b1);
            @(negedge clk);
            ev_strobe = 1'b0;
            check_all("rsvd R9");
            check("rsvd R9 done", 64'(load_done), 64'd0);
        end

        // Inputs toggling with no strobe: nothing loads.
        for (int k = 0; k < 5; k++) begin
            drive(TBL[k], 1'b0);
            @(negedge clk);
            check_all("idle R9");
            check("idle R9 done", 64'(load_done), 64'd0);
        end

        // Back-to-back events: the second one wins.
        drive(TBL[7], 1'b1);
        @(negedge clk);
        drive(TBL[1], 1'b1);
        @(negedge clk);
        ev_strobe = 1'b0;
        e_badva = TBL[1].va;
        e_ctx   = exp_ctx(TBL[1].va, TBL[1].pctx);
        e_xctx  = exp_xctx(TBL[1].va, TBL[1].pxctx);
        e_ehi   = exp_ehi(TBL[1].va, TBL[1].asid);
        e_code  = TBL[1].code;
        e_vec   = TBL[1].vec;
        check_all("b2b R8");
        check("b2b R8 done", 64'(load_done), 64'd1);

        // Reset applied over loaded registers.
        rst_n = 1'b0;
        @(negedge clk);
        e_badva = '0; e_ctx = '0; e_xctx = '0; e_ehi = '0; e_code = '0; e_vec = '0;
        check_all("rereset R10");
        check("rereset R10 done", 64'(load_done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule